// File: doc/BRIEF.md
# Split Instruction/Data Request Dispatcher

This block sits between a processor's request queue and the line controller of a split first-level cache. For the request at the head of the queue it picks the cache that owns the access: fetches go to the instruction cache, and loads, stores and atomics go to the data cache. It then decides, from the two tag lookups it is given, whether the request can be serviced now or whether a line must first be moved out of a cache. The outcome is one registered event with an operation, a target cache and a line address, handed to the line controller over a valid/ready pair.

The dispatcher keeps any line out of both caches at once. When a request misses its own cache but the line sits in the other one, the dispatcher first orders that copy evicted. When the selected cache has no free way, it orders the victim chosen by that cache evicted. In both cases the request stays at the queue head and is evaluated again once the eviction event has left. Only the request's own event dequeues it. Messages arriving from the next level take precedence: while one is pending, no processor event is issued.

Four counters record hits and misses per cache for each accepted demand event.

Top module: `disp_top`

## Requirements
- R1: Kind code 1 (fetch) targets the instruction cache (`evt_icache`=1). Codes 0 (load), 2 (store) and 3 (atomic) target the data cache. Demand ops are 0 for a load, 1 for a fetch and 2 for a store or atomic. Op 3 is an eviction.
- R2: A hit in the selected cache issues the demand event for `req_addr` one cycle later. `req_pop` is high while that event is accepted.
- R3: A miss in the selected cache with a hit in the other cache issues op 3 for `req_addr` in the other cache. `req_pop` stays low.
- R4: A miss in both caches with a free way in the selected cache issues the demand event for `req_addr`.
- R5: A miss in both caches with no free way issues op 3 in the selected cache for that cache's victim address. `req_pop` stays low.
- R6: Kind codes 4 to 7 issue no event. They raise `req_pop` in the same cycle and pulse `err_kind` high one cycle later.
- R7: A request seen with both lookups hitting raises `err_dual` one cycle later. The request is then served as a hit in its selected cache.
- R8: While `net_valid` is high, no new event is issued.
- R9: An issued event keeps its op, cache and address until `evt_ready` is high. `req_pop` stays low while it waits.
- R10: Each accepted demand event adds one to the hit or miss counter of its cache. Evictions add nothing.
- R11: After reset, `evt_valid`, `err_kind`, `err_dual` and all four counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is at the queue head |
| req_kind | input | 3 | Request kind code |
| req_addr | input | AW | Line address of the request |
| req_pop | output | 1 | Dequeue the head request this cycle |
| net_valid | input | 1 | A next-level message is pending (higher priority) |
| ic_hit | input | 1 | Instruction tag lookup hit for req_addr |
| ic_free | input | 1 | Instruction cache set has a free way |
| ic_victim | input | AW | Instruction cache victim line address |
| dc_hit | input | 1 | Data tag lookup hit for req_addr |
| dc_free | input | 1 | Data cache set has a free way |
| dc_victim | input | AW | Data cache victim line address |
| evt_valid | output | 1 | Event valid |
| evt_ready | input | 1 | Line controller accepts the event |
| evt_op | output | 2 | Event operation |
| evt_icache | output | 1 | Event targets the instruction cache |
| evt_addr | output | AW | Event line address |
| err_kind | output | 1 | Illegal kind code seen |
| err_dual | output | 1 | Line found in both caches |
| ic_hits | output | CW | Instruction cache hit count |
| ic_misses | output | CW | Instruction cache miss count |
| dc_hits | output | CW | Data cache hit count |
| dc_misses | output | CW | Data cache miss count |

## Verification
Some properties are checked by assertions on every cycle:
- a pending next-level message blocks new events;
- a stalled event holds steady;
- demand ops always go to the matching cache;
- a fresh demand event carries the queued address;
- illegal kinds and dual presence are flagged;
- counters step by one.

Other behaviour can only be shown by the directed scenarios, which supply tag outcomes that a cycle-local property cannot judge:
- the order of the decision (other-cache copy, then free way, then victim);
- the choice of victim address;
- the re-evaluation of a request after its eviction;
- the exact counter totals.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [2:0] {
    K_LOAD   = 3'd0,
    K_FETCH  = 3'd1,
    K_STORE  = 3'd2,
    K_ATOMIC = 3'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_FETCH = 2'd1,
    OP_WRITE = 2'd2,
    OP_EVICT = 2'd3
  } evt_op_e;

  localparam int NUM_STATS = 4;
  localparam int ST_IHIT   = 0;
  localparam int ST_IMISS  = 1;
  localparam int ST_DHIT   = 2;
  localparam int ST_DMISS  = 3;
endpackage

// File: rtl/disp_kind_decode.sv
module disp_kind_decode
  import disp_pkg::*;
(
  input  logic [2:0] kind,
  output logic       legal,
  output logic       use_icache,
  output evt_op_e    op
);
  always_comb begin
    legal      = 1'b1;
    use_icache = 1'b0;
    op         = OP_READ;
    case (kind)
      K_LOAD:   op = OP_READ;
      K_FETCH:  begin op = OP_FETCH; use_icache = 1'b1; end
      K_STORE,
      K_ATOMIC: op = OP_WRITE;
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/disp_route.sv
module disp_route
  import disp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          use_icache,
  input  evt_op_e       demand_op,
  input  logic [AW-1:0] req_addr,
  input  logic          ic_hit,
  input  logic          ic_free,
  input  logic [AW-1:0] ic_victim,
  input  logic          dc_hit,
  input  logic          dc_free,
  input  logic [AW-1:0] dc_victim,
  output evt_op_e       op,
  output logic          icache,
  output logic [AW-1:0] addr,
  output logic          hit
);
  logic          sel_hit, oth_hit, sel_free;
  logic [AW-1:0] sel_vic;

  assign sel_hit  = use_icache ? ic_hit    : dc_hit;
  assign oth_hit  = use_icache ? dc_hit    : ic_hit;
  assign sel_free = use_icache ? ic_free   : dc_free;
  assign sel_vic  = use_icache ? ic_victim : dc_victim;

  always_comb begin
    op     = demand_op;
    icache = use_icache;
    addr   = req_addr;
    hit    = 1'b0;
    if (sel_hit) begin
      hit = 1'b1;
    end else if (oth_hit) begin
      op     = OP_EVICT;
      icache = ~use_icache;
    end else if (!sel_free) begin
      op   = OP_EVICT;
      addr = sel_vic;
    end
  end
endmodule

// File: rtl/disp_stats.sv
module disp_stats #(
  parameter int N  = 4,
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       inc,
  output logic [N-1:0][CW-1:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + CW'(1);
    end

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (rst)
      inc[g] |=> cnt[g] == $past(cnt[g]) + CW'(1));
  end
endmodule

// File: rtl/disp_top.sv
module disp_top
  import disp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  output logic          req_pop,
  input  logic          net_valid,
  input  logic          ic_hit,
  input  logic          ic_free,
  input  logic [AW-1:0] ic_victim,
  input  logic          dc_hit,
  input  logic          dc_free,
  input  logic [AW-1:0] dc_victim,
  output logic          evt_valid,
  input  logic          evt_ready,
  output logic [1:0]    evt_op,
  output logic          evt_icache,
  output logic [AW-1:0] evt_addr,
  output logic          err_kind,
  output logic          err_dual,
  output logic [CW-1:0] ic_hits,
  output logic [CW-1:0] ic_misses,
  output logic [CW-1:0] dc_hits,
  output logic [CW-1:0] dc_misses
);
  logic          legal, use_ic, r_ic, r_hit, evt_hit;
  evt_op_e       dem_op, r_op;
  logic [AW-1:0] r_addr;
  logic          try_req, issue, accept, demand_acc;
  logic [NUM_STATS-1:0]         st_inc;
  logic [NUM_STATS-1:0][CW-1:0] st_cnt;

  disp_kind_decode u_dec (
    .kind(req_kind), .legal(legal), .use_icache(use_ic), .op(dem_op)
  );

  disp_route #(.AW(AW)) u_route (
    .use_icache(use_ic), .demand_op(dem_op), .req_addr(req_addr),
    .ic_hit(ic_hit), .ic_free(ic_free), .ic_victim(ic_victim),
    .dc_hit(dc_hit), .dc_free(dc_free), .dc_victim(dc_victim),
    .op(r_op), .icache(r_ic), .addr(r_addr), .hit(r_hit)
  );

  assign try_req    = req_valid & ~net_valid & ~evt_valid;
  assign issue      = try_req & legal;
  assign accept     = evt_valid & evt_ready;
  assign demand_acc = accept & (evt_op != OP_EVICT);
  assign req_pop    = demand_acc | (try_req & ~legal);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid  <= 1'b0;
      evt_op     <= OP_READ;
      evt_icache <= 1'b0;
      evt_addr   <= '0;
      evt_hit    <= 1'b0;
      err_kind   <= 1'b0;
      err_dual   <= 1'b0;
    end else begin
      if (issue) begin
        evt_valid  <= 1'b1;
        evt_op     <= r_op;
        evt_icache <= r_ic;
        evt_addr   <= r_addr;
        evt_hit    <= r_hit;
      end else if (accept) begin
        evt_valid  <= 1'b0;
      end
      err_kind <= try_req & ~legal;
      err_dual <= req_valid & ic_hit & dc_hit;
    end
  end

  assign st_inc[ST_IHIT]  = demand_acc &  evt_icache &  evt_hit;
  assign st_inc[ST_IMISS] = demand_acc &  evt_icache & ~evt_hit;
  assign st_inc[ST_DHIT]  = demand_acc & ~evt_icache &  evt_hit;
  assign st_inc[ST_DMISS] = demand_acc & ~evt_icache & ~evt_hit;

  disp_stats #(.N(NUM_STATS), .CW(CW)) u_stats (
    .clk(clk), .rst(rst), .inc(st_inc), .cnt(st_cnt)
  );

  assign ic_hits   = st_cnt[ST_IHIT];
  assign ic_misses = st_cnt[ST_IMISS];
  assign dc_hits   = st_cnt[ST_DHIT];
  assign dc_misses = st_cnt[ST_DMISS];

  p_route_r1: assert property (@(posedge clk) disable iff (rst)
    evt_valid && evt_op != OP_EVICT |-> evt_icache == (evt_op == OP_FETCH));

  p_demand_addr_r2: assert property (@(posedge clk) disable iff (rst)
    evt_valid && !$past(evt_valid) && evt_op != OP_EVICT |-> evt_addr == $past(req_addr));

  p_bad_kind_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && !net_valid && !evt_valid && req_kind[2] |=> !evt_valid && err_kind);

  p_dual_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && ic_hit && dc_hit |=> err_dual);

  p_prio_r8: assert property (@(posedge clk) disable iff (rst)
    net_valid && !evt_valid |=> !evt_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_addr) && $stable(evt_op) && $stable(evt_icache));
endmodule

// File: tb/sim_disp_top.sv
module sim_disp_top;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam time TCLK = 10;

  logic clk = 0, rst = 1;
  logic req_valid = 0, net_valid = 0, evt_ready = 1;
  logic [2:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0, ic_victim = 0, dc_victim = 0;
  logic ic_hit = 0, ic_free = 0, dc_hit = 0, dc_free = 0;
  logic req_pop, evt_valid, evt_icache, err_kind, err_dual;
  logic [1:0] evt_op;
  logic [AW-1:0] evt_addr;
  logic [CW-1:0] ic_hits, ic_misses, dc_hits, dc_misses;

  int checks = 0, errors = 0, cycles = 0;
  int e_ih = 0, e_im = 0, e_dh = 0, e_dm = 0;

  always #(TCLK/2) clk = ~clk;

  disp_top #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_pop(req_pop), .net_valid(net_valid),
    .ic_hit(ic_hit), .ic_free(ic_free), .ic_victim(ic_victim),
    .dc_hit(dc_hit), .dc_free(dc_free), .dc_victim(dc_victim),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_op(evt_op),
    .evt_icache(evt_icache), .evt_addr(evt_addr), .err_kind(err_kind),
    .err_dual(err_dual), .ic_hits(ic_hits), .ic_misses(ic_misses),
    .dc_hits(dc_hits), .dc_misses(dc_misses)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic chk_counts(string tag);
    chk({tag, " ic_hits"}, 64'(ic_hits), 64'(e_ih));
    chk({tag, " ic_misses"}, 64'(ic_misses), 64'(e_im));
    chk({tag, " dc_hits"}, 64'(dc_hits), 64'(e_dh));
    chk({tag, " dc_misses"}, 64'(dc_misses), 64'(e_dm));
  endtask

  task automatic drive(logic [2:0] k, logic [AW-1:0] a, logic ih, logic dh,
                       logic ifr, logic dfr, logic [AW-1:0] iv, logic [AW-1:0] dv);
    req_valid = 1; req_kind = k; req_addr = a;
    ic_hit = ih; dc_hit = dh; ic_free = ifr; dc_free = dfr;
    ic_victim = iv; dc_victim = dv;
  endtask

  // called at a negedge with evt_ready = 1
  task automatic run_req(string tag, logic [2:0] k, logic [AW-1:0] a, logic ih, logic dh,
                         logic ifr, logic dfr, logic [AW-1:0] iv, logic [AW-1:0] dv,
                         logic [1:0] eop, logic eic, logic [AW-1:0] eaddr,
                         logic ehit, logic edual);
    drive(k, a, ih, dh, ifr, dfr, iv, dv);
    @(posedge clk); @(negedge clk);
    chk({tag, " evt_valid"}, 64'(evt_valid), 64'd1);
    chk({tag, " evt_op"}, 64'(evt_op), 64'(eop));
    chk({tag, " evt_icache"}, 64'(evt_icache), 64'(eic));
    chk({tag, " evt_addr"}, 64'(evt_addr), 64'(eaddr));
    chk({tag, " req_pop"}, 64'(req_pop), 64'(eop != 2'd3));
    chk({tag, " err_dual"}, 64'(err_dual), 64'(edual));
    req_valid = 0;
    if (eop != 2'd3) begin
      if (eic) begin if (ehit) e_ih++; else e_im++; end
      else     begin if (ehit) e_dh++; else e_dm++; end
    end
    @(posedge clk); @(negedge clk);
    chk({tag, " evt_valid after accept"}, 64'(evt_valid), 64'd0);
    chk_counts(tag);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R11 evt_valid", 64'(evt_valid), 0);
    chk("R11 err_kind", 64'(err_kind), 0);
    chk("R11 err_dual", 64'(err_dual), 0);
    chk_counts("R11");
  endtask

  task automatic t_hits;
    run_req("R1 R2 load hit", 3'd0, 32'h100, 0, 1, 1, 1, 0, 0, 2'd0, 0, 32'h100, 1, 0);
    run_req("R1 R2 fetch hit", 3'd1, 32'h140, 1, 0, 1, 1, 0, 0, 2'd1, 1, 32'h140, 1, 0);
    run_req("R1 store hit", 3'd2, 32'h180, 0, 1, 0, 0, 0, 0, 2'd2, 0, 32'h180, 1, 0);
    run_req("R1 atomic hit", 3'd3, 32'h1c0, 0, 1, 0, 0, 0, 0, 2'd2, 0, 32'h1c0, 1, 0);
  endtask

  task automatic t_other_cache;
    run_req("R3 load in icache", 3'd0, 32'h200, 1, 0, 1, 1, 0, 0, 2'd3, 1, 32'h200, 0, 0);
    run_req("R4 load re-eval", 3'd0, 32'h200, 0, 0, 1, 1, 0, 0, 2'd0, 0, 32'h200, 0, 0);
    run_req("R3 fetch in dcache", 3'd1, 32'h240, 0, 1, 0, 0, 0, 0, 2'd3, 0, 32'h240, 0, 0);
    run_req("R4 fetch re-eval", 3'd1, 32'h240, 0, 0, 1, 0, 0, 0, 2'd1, 1, 32'h240, 0, 0);
  endtask

  task automatic t_victim;
    run_req("R5 store no way", 3'd2, 32'h300, 0, 0, 1, 0, 32'h11, 32'h7c0, 2'd3, 0, 32'h7c0, 0, 0);
    run_req("R5 fetch no way", 3'd1, 32'h340, 0, 0, 0, 1, 32'h5c0, 32'h22, 2'd3, 1, 32'h5c0, 0, 0);
    run_req("R4 store free way", 3'd2, 32'h300, 0, 0, 0, 1, 0, 0, 2'd2, 0, 32'h300, 0, 0);
  endtask

  task automatic t_bad_kind;
    drive(3'd5, 32'h400, 0, 1, 1, 1, 0, 0);
    #1 chk("R6 pop same cycle", 64'(req_pop), 1);
    @(posedge clk); @(negedge clk);
    chk("R6 err_kind", 64'(err_kind), 1);
    chk("R6 no event", 64'(evt_valid), 0);
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    chk("R6 err_kind clears", 64'(err_kind), 0);
    chk_counts("R6");
  endtask

  task automatic t_dual;
    run_req("R7 dual presence", 3'd0, 32'h500, 1, 1, 1, 1, 0, 0, 2'd0, 0, 32'h500, 1, 1);
  endtask

  task automatic t_priority;
    net_valid = 1;
    drive(3'd0, 32'h600, 0, 1, 1, 1, 0, 0);
    @(posedge clk); @(negedge clk);
    chk("R8 blocked 1", 64'(evt_valid), 0);
    chk("R8 no pop", 64'(req_pop), 0);
    @(posedge clk); @(negedge clk);
    chk("R8 blocked 2", 64'(evt_valid), 0);
    net_valid = 0;
    run_req("R8 after release", 3'd0, 32'h600, 0, 1, 1, 1, 0, 0, 2'd0, 0, 32'h600, 1, 0);
  endtask

  task automatic t_stall;
    evt_ready = 0;
    drive(3'd2, 32'h700, 0, 1, 1, 1, 0, 0);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R9 held valid", 64'(evt_valid), 1);
      chk("R9 held addr", 64'(evt_addr), 64'h700);
      chk("R9 held op", 64'(evt_op), 2);
      chk("R9 no pop", 64'(req_pop), 0);
      @(posedge clk); @(negedge clk);
    end
    chk_counts("R10 no count while held");
    evt_ready = 1;
    #1 chk("R9 pop on accept", 64'(req_pop), 1);
    e_dh++;
    @(posedge clk); @(negedge clk);
    chk("R9 cleared", 64'(evt_valid), 0);
    chk_counts("R10 after held");
  endtask

  initial begin
    t_reset();
    t_hits();
    t_other_cache();
    t_victim();
    t_bad_kind();
    t_dual();
    t_priority();
    t_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule